// File: doc/BRIEF.md
# Two-Level Hardware Breakpoint Trigger

This block watches a processor for debug events. Four comparators look at the program counter. One comparator looks at the address of each bus access, and one looks at its data through a mask. The matches are combined into a trigger with one or two levels. Each level picks its own set of conditions and joins them with a logical AND or a logical OR. When the last level fires, the block either raises a halt request or raises a debug interrupt request, as configured. The request stays up until the processor acknowledges it.

Software sets the unit up with single-cycle register writes. Writing the control register also re-arms the trigger at level 1. Bus accesses that the debug interface itself starts are marked with an origin flag. Such accesses are invisible to the comparators, so a debugger can read and write memory without disturbing an armed trigger.

Top module: `dbg_trigger_unit`

## Requirements
- R1: Four PC comparators each hold a reference written at select 0..3. While `pc_valid` is high, comparator k matches when `pc_value` equals its reference. The PC condition of a level is true when any comparator enabled for that level matches.
- R2: The address comparator (select 4) matches on an exact 24-bit equality with `bus_addr` while `bus_valid` is high.
- R3: The data comparator (reference at select 5, mask at select 6, mask reset to all ones) matches when `bus_data & mask` equals `reference & mask` while `bus_valid` is high.
- R4: An access with `bus_dbg` high never matches the address or data comparator and never changes the trigger state or the requests.
- R5: Control register (select 7) layout, per level: bits [5:0] are the level-1 enables (bit k = PC comparator k, bit 4 = address, bit 5 = data), and bits [11:6] are the level-2 enables in the same order. Bit 13 and bit 14 select AND (1) or OR (0) for level 1 and level 2. Under OR, a level fires when any enabled condition holds. Under AND, it fires when every enabled condition holds. A level with no enables never fires.
- R6: When control bit 12 is set, a level-1 hit moves the unit to level 2 instead of firing. Level 2 is evaluated only from the next cycle on.
- R7: When the trigger fires, control bit 15 selects the response: 0 raises `halt_req` and 1 raises `irq_req`. The request and the state change are visible one clock edge after the cycle of the hit.
- R8: A raised request stays high until its acknowledge input is seen. If a fire and an acknowledge of the same request arrive in the same cycle, the request stays high. A control write does not clear requests.
- R9: Once fired, the unit stays fired whatever the inputs are, until a control write. After a control write, `trig_level` reads level 1 on the next cycle.
- R10: `trig_level` encodes 0 = armed at level 1, 1 = armed at level 2, 2 = fired, and never takes the value 3. After reset it reads 0, and both requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pc_valid | input | 1 | `pc_value` holds a PC to compare this cycle |
| pc_value | input | 32 | Current program counter |
| bus_valid | input | 1 | A bus access is present this cycle |
| bus_dbg | input | 1 | The access was started by the debug interface |
| bus_addr | input | 24 | Access address |
| bus_data | input | 32 | Access data |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write value |
| halt_ack | input | 1 | Clears `halt_req` |
| irq_ack | input | 1 | Clears `irq_req` |
| halt_req | output | 1 | Processor halt request |
| irq_req | output | 1 | Debug interrupt request |
| trig_level | output | 2 | Current trigger level |

## Verification
The bench builds the block with its default parameters: four PC comparators, a 24-bit address and 32-bit data. With these values every control bit position stated in the requirements is live.

For level 1, the bench sweeps every subset of {PC, address, data} enables under both AND and OR, against all eight hit patterns. This covers the empty-level case, and the bench computes the expected fire decision arithmetically.

It also crosses each of the four PC comparators with each reference value. Directed sequences then cover:
- the two-level ordering,
- the two response types,
- request hold and acknowledge, including fire and acknowledge in the same cycle,
- masked data bits,
- debug-origin accesses.

// File: rtl/trig_pkg.sv
package trig_pkg;
    typedef enum logic [1:0] {
        TRG_ARM1  = 2'd0,
        TRG_ARM2  = 2'd1,
        TRG_FIRED = 2'd2
    } trg_state_e;

    localparam int SEL_W = 3;
    localparam logic [SEL_W-1:0] SEL_ADDR = 3'd4;
    localparam logic [SEL_W-1:0] SEL_DATA = 3'd5;
    localparam logic [SEL_W-1:0] SEL_MASK = 3'd6;
    localparam logic [SEL_W-1:0] SEL_CTL  = 3'd7;
endpackage

// File: rtl/trig_pc_bank.sv
module trig_pc_bank #(
    parameter int N_PC = 4,
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_PC-1:0] ref_we,
    input  logic [PC_W-1:0] ref_wval,
    input  logic            pc_valid,
    input  logic [PC_W-1:0] pc_value,
    output logic [N_PC-1:0] pc_hit
);
    for (genvar g = 0; g < N_PC; g++) begin : g_cmp
        logic [PC_W-1:0] ref_d, ref_q;

        always_comb begin
            ref_d = ref_q;
            if (ref_we[g]) ref_d = ref_wval;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ref_q <= '0;
            else        ref_q <= ref_d;
        end

        assign pc_hit[g] = pc_valid && (pc_value == ref_q);
    end
endmodule

// File: rtl/trig_bus_match.sv
module trig_bus_match #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_we,
    input  logic              data_we,
    input  logic              mask_we,
    input  logic [DATA_W-1:0] wval,
    input  logic              bus_valid,
    input  logic              bus_dbg,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    output logic              addr_hit,
    output logic              data_hit
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] mask;
    } bus_ref_t;

    bus_ref_t r_d, r_q;
    logic     qualified;

    always_comb begin
        r_d = r_q;
        if (addr_we) r_d.addr = wval[ADDR_W-1:0];
        if (data_we) r_d.data = wval;
        if (mask_we) r_d.mask = wval;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.addr <= '0;
            r_q.data <= '0;
            r_q.mask <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    // accesses from the debug port are never qualified
    assign qualified = bus_valid && !bus_dbg;
    assign addr_hit  = qualified && (bus_addr == r_q.addr);
    assign data_hit  = qualified && ((bus_data & r_q.mask) == (r_q.data & r_q.mask));
endmodule

// File: rtl/trig_seq.sv
module trig_seq
    import trig_pkg::*;
#(
    parameter int N_PC = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ctl_we,
    input  logic [2*(N_PC+2)+3:0]      ctl_wval,
    input  logic [N_PC-1:0]            pc_hit,
    input  logic                       addr_hit,
    input  logic                       data_hit,
    input  logic                       halt_ack,
    input  logic                       irq_ack,
    output logic                       halt_req,
    output logic                       irq_req,
    output trg_state_e                 state
);
    localparam int EN_W   = N_PC + 2;
    localparam int L1_LSB = 0;
    localparam int L2_LSB = EN_W;
    localparam int TWO_B  = 2 * EN_W;
    localparam int AND1_B = TWO_B + 1;
    localparam int AND2_B = TWO_B + 2;
    localparam int RESP_B = TWO_B + 3;
    localparam int CTL_W  = TWO_B + 4;

    typedef struct packed {
        trg_state_e       st;
        logic             halt;
        logic             irq;
        logic [CTL_W-1:0] ctl;
    } seq_t;

    seq_t s_d, s_q;
    logic l1_hit, l2_hit, fire;

    function automatic logic level_eval(input logic [EN_W-1:0] en,
                                        input logic            use_and,
                                        input logic [N_PC-1:0] pm,
                                        input logic            ah,
                                        input logic            dh);
        logic pc_en, pc_c, a_en, d_en, any_en;
        pc_en  = |en[N_PC-1:0];
        pc_c   = |(en[N_PC-1:0] & pm);
        a_en   = en[N_PC];
        d_en   = en[N_PC+1];
        any_en = pc_en | a_en | d_en;
        if (use_and)
            return any_en && (!pc_en || pc_c) && (!a_en || ah) && (!d_en || dh);
        return pc_c || (a_en && ah) || (d_en && dh);
    endfunction

    assign l1_hit = level_eval(s_q.ctl[L1_LSB +: EN_W], s_q.ctl[AND1_B], pc_hit, addr_hit, data_hit);
    assign l2_hit = level_eval(s_q.ctl[L2_LSB +: EN_W], s_q.ctl[AND2_B], pc_hit, addr_hit, data_hit);

    always_comb begin
        s_d      = s_q;
        fire     = 1'b0;
        s_d.halt = s_q.halt && !halt_ack;
        s_d.irq  = s_q.irq && !irq_ack;
        if (ctl_we) begin
            s_d.ctl = ctl_wval;
            s_d.st  = TRG_ARM1;
        end else begin
            unique case (s_q.st)
                TRG_ARM1: begin
                    if (l1_hit) begin
                        if (s_q.ctl[TWO_B]) s_d.st = TRG_ARM2;
                        else                fire   = 1'b1;
                    end
                end
                TRG_ARM2:  if (l2_hit) fire = 1'b1;
                default:   s_d.st = TRG_FIRED;
            endcase
        end
        if (fire) begin
            s_d.st = TRG_FIRED;
            if (s_q.ctl[RESP_B]) s_d.irq  = 1'b1;
            else                 s_d.halt = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st   <= TRG_ARM1;
            s_q.halt <= 1'b0;
            s_q.irq  <= 1'b0;
            s_q.ctl  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign halt_req = s_q.halt;
    assign irq_req  = s_q.irq;
    assign state    = s_q.st;
endmodule

// File: rtl/dbg_trigger_unit.sv
module dbg_trigger_unit
    import trig_pkg::*;
#(
    parameter int N_PC   = 4,
    parameter int PC_W   = 32,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    parameter int CFG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pc_valid,
    input  logic [PC_W-1:0]   pc_value,
    input  logic              bus_valid,
    input  logic              bus_dbg,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              halt_ack,
    input  logic              irq_ack,
    output logic              halt_req,
    output logic              irq_req,
    output logic [1:0]        trig_level
);
    localparam int CTL_W = 2 * (N_PC + 2) + 4;

    logic [N_PC-1:0] pc_we;
    logic [N_PC-1:0] pc_hit;
    logic            addr_we, data_we, mask_we, ctl_we;
    logic            addr_hit, data_hit;
    trg_state_e      st;

    always_comb begin
        pc_we = '0;
        for (int k = 0; k < N_PC; k++)
            pc_we[k] = cfg_we && (cfg_sel == SEL_W'(k));
    end

    assign addr_we = cfg_we && (cfg_sel == SEL_ADDR);
    assign data_we = cfg_we && (cfg_sel == SEL_DATA);
    assign mask_we = cfg_we && (cfg_sel == SEL_MASK);
    assign ctl_we  = cfg_we && (cfg_sel == SEL_CTL);

    trig_pc_bank #(.N_PC(N_PC), .PC_W(PC_W)) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_we   (pc_we),
        .ref_wval (cfg_wdata[PC_W-1:0]),
        .pc_valid (pc_valid),
        .pc_value (pc_value),
        .pc_hit   (pc_hit)
    );

    trig_bus_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_we   (addr_we),
        .data_we   (data_we),
        .mask_we   (mask_we),
        .wval      (cfg_wdata[DATA_W-1:0]),
        .bus_valid (bus_valid),
        .bus_dbg   (bus_dbg),
        .bus_addr  (bus_addr),
        .bus_data  (bus_data),
        .addr_hit  (addr_hit),
        .data_hit  (data_hit)
    );

    trig_seq #(.N_PC(N_PC)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_we   (ctl_we),
        .ctl_wval (cfg_wdata[CTL_W-1:0]),
        .pc_hit   (pc_hit),
        .addr_hit (addr_hit),
        .data_hit (data_hit),
        .halt_ack (halt_ack),
        .irq_ack  (irq_ack),
        .halt_req (halt_req),
        .irq_req  (irq_req),
        .state    (st)
    );

    assign trig_level = st;
endmodule

// File: rtl/trig_checker.sv
module trig_checker #(
    parameter int SEL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pc_valid,
    input logic             bus_valid,
    input logic             bus_dbg,
    input logic             cfg_we,
    input logic [SEL_W-1:0] cfg_sel,
    input logic             halt_ack,
    input logic             irq_ack,
    input logic             halt_req,
    input logic             irq_req,
    input logic [1:0]       trig_level
);
    logic ctl_wr;
    assign ctl_wr = cfg_we && (cfg_sel == SEL_W'(7));

    assert_level_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trig_level != 2'd3);

    assert_halt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && !halt_ack) |=> halt_req);

    assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> irq_req);

    assert_fired_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_level == 2'd2 && !ctl_wr) |=> (trig_level == 2'd2));

    assert_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (trig_level == 2'd0));

    assert_dbg_no_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_level == 2'd0 && bus_valid && bus_dbg && !pc_valid && !cfg_we)
        |=> (trig_level == 2'd0));

    assert_l2_forward_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_level == 2'd1 && !ctl_wr) |=> (trig_level != 2'd0));

    assert_fire_requests_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_level[1]) |-> (halt_req || irq_req));
endmodule

bind dbg_trigger_unit trig_checker #(.SEL_W(trig_pkg::SEL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc_valid   (pc_valid),
    .bus_valid  (bus_valid),
    .bus_dbg    (bus_dbg),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .halt_ack   (halt_ack),
    .irq_ack    (irq_ack),
    .halt_req   (halt_req),
    .irq_req    (irq_req),
    .trig_level (trig_level)
);

// File: tb/sim_dbg_trigger_unit.sv
module sim_dbg_trigger_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        pc_valid = 0, bus_valid = 0, bus_dbg = 0;
    logic [31:0] pc_value = 0;
    logic [23:0] bus_addr = 0;
    logic [31:0] bus_data = 0;
    logic        cfg_we = 0;
    logic [2:0]  cfg_sel = 0;
    logic [31:0] cfg_wdata = 0;
    logic        halt_ack = 0, irq_ack = 0;
    logic        halt_req, irq_req;
    logic [1:0]  trig_level;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_trigger_unit u0 (
        .clk(clk), .rst_n(rst_n), .pc_valid(pc_valid), .pc_value(pc_value),
        .bus_valid(bus_valid), .bus_dbg(bus_dbg), .bus_addr(bus_addr),
        .bus_data(bus_data), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .halt_ack(halt_ack), .irq_ack(irq_ack),
        .halt_req(halt_req), .irq_req(irq_req), .trig_level(trig_level)
    );

    localparam logic [23:0] A_REF = 24'h123456;
    localparam logic [31:0] D_REF = 32'hA5A5_0000;
    localparam logic [31:0] D_MSK = 32'hFFFF_0000;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] val);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = val;
        @(posedge clk); @(negedge clk);
        cfg_we = 0;
    endtask

    // drive one cycle of activity, sample after the edge
    task automatic step(input logic pv, input logic [31:0] pc, input logic bv,
                        input logic dbg, input logic [23:0] a, input logic [31:0] d);
        pc_valid = pv; pc_value = pc; bus_valid = bv; bus_dbg = dbg;
        bus_addr = a; bus_data = d;
        @(posedge clk); @(negedge clk);
        pc_valid = 0; bus_valid = 0; bus_dbg = 0;
    endtask

    task automatic ack_all();
        halt_ack = 1; irq_ack = 1;
        @(posedge clk); @(negedge clk);
        halt_ack = 0; irq_ack = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(trig_level, 0, "R10 reset level");
        chk(halt_req, 0, "R10 reset halt");
        chk(irq_req, 0, "R10 reset irq");
        rst_n = 1;
        @(negedge clk);

        for (int k = 0; k < 4; k++) wr(3'(k), 32'h1000 + 32'h100 * k);
        wr(4, {8'h0, A_REF});
        wr(5, D_REF);
        wr(6, D_MSK);

        // R1: each PC comparator against each reference
        for (int k = 0; k < 4; k++) begin
            for (int j = 0; j < 4; j++) begin
                wr(7, 32'(1) << k);
                step(1, 32'h1000 + 32'h100 * j, 0, 0, 0, 0);
                chk(trig_level, (j == k) ? 2 : 0, $sformatf("R1 cmp%0d pc%0d", k, j));
                ack_all();
            end
        end

        // R5/R2/R3/R7: sweep enable subsets, combine mode, hit patterns
        for (int m = 0; m < 2; m++) begin
            for (int e = 0; e < 8; e++) begin
                for (int h = 0; h < 8; h++) begin
                    logic [31:0] ctl;
                    logic        exp;
                    ctl = (e[0] ? 32'h1 : 0) | (e[1] ? 32'h10 : 0) | (e[2] ? 32'h20 : 0)
                        | (m[0] ? 32'h2000 : 0);
                    if (m == 1) exp = (e != 0) && ((h & e) == e);
                    else        exp = (h & e) != 0;
                    wr(7, ctl);
                    step(1, h[0] ? 32'h1000 : 32'h2000, 1, 0,
                         h[1] ? A_REF : 24'h654321,
                         h[2] ? 32'hA5A5_1234 : 32'h5A5A_1234);
                    chk(trig_level, exp ? 2 : 0, $sformatf("R5 m%0d e%0d h%0d level", m, e, h));
                    chk(halt_req, exp, $sformatf("R7 m%0d e%0d h%0d halt", m, e, h));
                    chk(irq_req, 0, "R7 irq stays low under halt response");
                    ack_all();
                end
            end
        end

        // R3: masked-out data bits ignored, masked-in bits compared
        wr(7, 32'h20);
        step(0, 0, 1, 0, 0, 32'hA5A5_FFFF);
        chk(trig_level, 2, "R3 low bits masked");
        ack_all();
        wr(7, 32'h20);
        step(0, 0, 1, 0, 0, 32'hA5A4_0000);
        chk(trig_level, 0, "R3 masked bit differs");
        // R2: exact address
        wr(7, 32'h10);
        step(0, 0, 1, 0, A_REF ^ 24'h800000, 0);
        chk(trig_level, 0, "R2 top address bit differs");

        // R4: debug-origin access ignored
        wr(7, 32'h30);
        step(0, 0, 1, 1, A_REF, D_REF);
        chk(trig_level, 0, "R4 debug access level");
        chk(halt_req, 0, "R4 debug access halt");

        // R6/R7/R8/R9: two levels, irq response
        wr(7, 32'h1 | 32'h400 | 32'h1000 | 32'h8000);
        step(0, 0, 1, 0, A_REF, 0);
        chk(trig_level, 0, "R6 level2 condition before level1");
        step(1, 32'h1000, 1, 0, A_REF, 0);
        chk(trig_level, 1, "R6 both hit same cycle only arms level2");
        chk(irq_req, 0, "R6 no request at level1");
        step(1, 32'h1000, 0, 0, 0, 0);
        chk(trig_level, 1, "R6 level1 condition at level2");
        step(0, 0, 1, 0, A_REF, 0);
        chk(trig_level, 2, "R6 level2 fires");
        chk(irq_req, 1, "R7 irq response");
        chk(halt_req, 0, "R7 no halt under irq response");
        repeat (5) @(negedge clk);
        chk(irq_req, 1, "R8 irq held");
        irq_ack = 1; @(posedge clk); @(negedge clk); irq_ack = 0;
        chk(irq_req, 0, "R8 irq cleared by ack");
        chk(trig_level, 2, "R9 fired after ack");
        step(1, 32'h1000, 1, 0, A_REF, 0);
        chk(trig_level, 2, "R9 fired ignores hits");
        chk(irq_req, 0, "R9 no new request while fired");

        // R8: control write keeps request; fire with ack in same cycle keeps it
        wr(7, 32'h1);
        step(1, 32'h1000, 0, 0, 0, 0);
        chk(halt_req, 1, "R8 halt raised");
        wr(7, 32'h1);
        chk(trig_level, 0, "R9 rearm");
        chk(halt_req, 1, "R8 control write keeps halt");
        halt_ack = 1;
        step(1, 32'h1000, 0, 0, 0, 0);
        halt_ack = 0;
        chk(halt_req, 1, "R8 fire wins over ack");
        ack_all();
        chk(halt_req, 0, "R8 ack clears");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule